// File: doc/BRIEF.md
# Four-Way Pseudo-LRU Replacement Tracker

This block tracks recency of use across the four slots of a small fully associative instruction translation buffer and names the slot to overwrite on the next refill. It holds a 6-bit pairwise ordering state, L[5:0]. Each bit records which of two slots was touched more recently. Whenever a slot is hit, or has just been refilled from the larger unified buffer, the owner pulses a use strobe with that slot's index, and the block moves the state accordingly.

A victim decoder compares the state against one fixed pattern per slot and reports the matching slot. When no pattern matches, the state is inconsistent and the victim-valid flag drops. Software may overwrite the whole state through a direct write port, for instance when restoring a saved context. The current state is always visible for readback.

Tag storage, address matching and copying entries are left to the surrounding logic.

Top module: `plru4_tracker`

## Requirements
- R1: While reset is high and after it is released, with no other stimulus, `state_o` equals the reset state (all zeros by default), `victim_o` is 3 and `victim_ok_o` is 1.
- R2: A use strobe for slot 0 clears L5, L4 and L3 and keeps L2, L1 and L0 (L5 is bit 5 of `state_o`, L0 is bit 0).
- R3: A use strobe for slot 1 sets L5, clears L2 and L1, and keeps L4, L3 and L0.
- R4: A use strobe for slot 2 sets L4 and L2, clears L0, and keeps L5, L3 and L1.
- R5: A use strobe for slot 3 sets L3, L1 and L0 and keeps L5, L4 and L2.
- R6: `victim_o` names the slot whose pattern the state matches, and `victim_ok_o` is 1. Slot 0 matches when L5, L4 and L3 are all 1. Slot 1 matches when L5=0, L2=1 and L1=1. Slot 2 matches when L4=0, L2=0 and L0=1. Slot 3 matches when L3=0, L1=0 and L0=0. Slots are checked in the order 0, 1, 2, 3.
- R7: A state that matches none of the four patterns (for example 6'b000010) gives `victim_ok_o`=0 and `victim_o`=0.
- R8: A write pulse loads `wr_state_i` into the whole state. When a write and a use strobe arrive in the same cycle, the write wins and the use strobe has no effect.
- R9: `state_o`, `victim_o` and `victim_ok_o` all change on the clock edge that samples the strobe or write. The victim outputs always describe the state shown on `state_o` in the same cycle.
- R10: In a cycle with neither a use strobe nor a write, the state and victim outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_vld_i | input | 1 | Slot hit or refill strobe |
| use_idx_i | input | 2 | Index of the slot used |
| wr_en_i | input | 1 | Direct state write pulse |
| wr_state_i | input | 6 | State value to load |
| victim_o | output | 2 | Slot to replace next |
| victim_ok_o | output | 1 | State matches a victim pattern |
| state_o | output | 6 | Current ordering state |

## Verification
The bench builds the tracker with the default all-zero reset state, so slot 3 is the first victim. From that start, use strobes alone reach every legal state. Direct writes bring the inconsistent states within reach, and a sweep writes all 64 codes to cover every pattern and every illegal code. A long mixed sequence then interleaves writes, strobes and idle cycles, including writes that collide with strobes, and compares the outputs after every edge.

// File: rtl/plru4_pkg.sv
package plru4_pkg;
  localparam int N_SLOTS = 4;
  localparam int IDX_W   = $clog2(N_SLOTS);
  localparam int ST_W    = N_SLOTS * (N_SLOTS - 1) / 2;

  typedef logic [ST_W-1:0]  state_t;
  typedef logic [IDX_W-1:0] idx_t;

  // Bits of the state that relate a slot to the other three.
  function automatic state_t touch_mask(input int slot);
    case (slot)
      0:       return 6'b111000;
      1:       return 6'b100110;
      2:       return 6'b010101;
      default: return 6'b001011;
    endcase
  endfunction

  // Values those bits take once the slot becomes the newest.
  function automatic state_t newest_val(input int slot);
    case (slot)
      0:       return 6'b000000;
      1:       return 6'b100000;
      2:       return 6'b010100;
      default: return 6'b001011;
    endcase
  endfunction
endpackage

// File: rtl/plru4_update.sv
module plru4_update
  import plru4_pkg::*;
(
  input  state_t cur_i,
  input  idx_t   slot_i,
  output state_t nxt_o
);
  state_t cand [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign cand[s] = (cur_i & ~touch_mask(s)) | newest_val(s);
  end

  assign nxt_o = cand[slot_i];
endmodule

// File: rtl/plru4_victim.sv
module plru4_victim
  import plru4_pkg::*;
(
  input  state_t st_i,
  output idx_t   victim_o,
  output logic   ok_o
);
  logic [N_SLOTS-1:0] hit;

  // A slot is oldest when every bit it shares reads opposite to "newest".
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_match
    assign hit[s] = ((st_i & touch_mask(s)) == (~newest_val(s) & touch_mask(s)));
  end

  always_comb begin
    victim_o = '0;
    ok_o     = 1'b0;
    for (int s = N_SLOTS - 1; s >= 0; s--) begin
      if (hit[s]) begin
        victim_o = idx_t'(s);
        ok_o     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/plru4_tracker.sv
module plru4_tracker
  import plru4_pkg::*;
#(
  parameter logic [5:0] RST_STATE = 6'b000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       use_vld_i,
  input  logic [1:0] use_idx_i,
  input  logic       wr_en_i,
  input  logic [5:0] wr_state_i,
  output logic [1:0] victim_o,
  output logic       victim_ok_o,
  output logic [5:0] state_o
);
  state_t state_q, upd_st, next_st;
  idx_t   vic_nxt, vic_q;
  logic   ok_nxt, ok_q;
  state_t rst_st;
  idx_t   rst_vic;
  logic   rst_ok;

  plru4_update u_upd (.cur_i(state_q), .slot_i(use_idx_i), .nxt_o(upd_st));

  always_comb begin
    if (wr_en_i)        next_st = wr_state_i;
    else if (use_vld_i) next_st = upd_st;
    else                next_st = state_q;
  end

  plru4_victim u_vic_nxt (.st_i(next_st), .victim_o(vic_nxt), .ok_o(ok_nxt));
  plru4_victim u_vic_rst (.st_i(RST_STATE), .victim_o(rst_vic), .ok_o(rst_ok));
  assign rst_st = RST_STATE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= rst_st;
      vic_q   <= rst_vic;
      ok_q    <= rst_ok;
    end else begin
      state_q <= next_st;
      vic_q   <= vic_nxt;
      ok_q    <= ok_nxt;
    end
  end

  assign state_o     = state_q;
  assign victim_o    = vic_q;
  assign victim_ok_o = ok_q;

  a_r2_use_slot0: assert property (@(posedge clk) disable iff (rst)
    (use_vld_i && !wr_en_i && use_idx_i == 2'd0)
      |=> (state_q[5:3] == 3'b000 && state_q[2:0] == $past(state_q[2:0])));

  a_r3_use_slot1: assert property (@(posedge clk) disable iff (rst)
    (use_vld_i && !wr_en_i && use_idx_i == 2'd1)
      |=> (state_q[5] && state_q[2:1] == 2'b00 &&
           state_q[4:3] == $past(state_q[4:3]) && state_q[0] == $past(state_q[0])));

  a_r4_use_slot2: assert property (@(posedge clk) disable iff (rst)
    (use_vld_i && !wr_en_i && use_idx_i == 2'd2)
      |=> (state_q[4] && state_q[2] && !state_q[0] &&
           state_q[5] == $past(state_q[5]) && state_q[3] == $past(state_q[3]) &&
           state_q[1] == $past(state_q[1])));

  a_r5_use_slot3: assert property (@(posedge clk) disable iff (rst)
    (use_vld_i && !wr_en_i && use_idx_i == 2'd3)
      |=> (state_q[3] && state_q[1] && state_q[0] &&
           state_q[5:4] == $past(state_q[5:4]) && state_q[2] == $past(state_q[2])));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (state_q == $past(wr_state_i)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !use_vld_i) |=> ($stable(state_q) && $stable(vic_q) && $stable(ok_q)));

  a_r6_victim_oldest: assert property (@(posedge clk) disable iff (rst)
    (ok_q && vic_q == 2'd0) |-> (state_q[5:3] == 3'b111));

  a_r7_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    (state_q == 6'b000010) |-> (!ok_q && vic_q == 2'd0));
endmodule

// File: tb/plru4_tracker_test.sv
module plru4_tracker_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       use_vld = 1'b0;
  logic [1:0] use_idx = 2'd0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_state = 6'd0;
  logic [1:0] victim;
  logic       victim_ok;
  logic [5:0] state;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [5:0] m_st;

  always #10 clk = ~clk;

  plru4_tracker uut (
    .clk(clk), .rst(rst), .use_vld_i(use_vld), .use_idx_i(use_idx),
    .wr_en_i(wr_en), .wr_state_i(wr_state),
    .victim_o(victim), .victim_ok_o(victim_ok), .state_o(state)
  );

  function automatic int ref_victim(input logic [5:0] s);
    if (s[5] && s[4] && s[3])         return 0;
    else if (!s[5] && s[2] && s[1])   return 1;
    else if (!s[4] && !s[2] && s[0])  return 2;
    else if (!s[3] && !s[1] && !s[0]) return 3;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int v;
    v = ref_victim(m_st);
    check(req, int'(state), int'(m_st));
    if (v < 0) begin
      check("R7 illegal ok", int'(victim_ok), 0);
      check("R7 illegal idx", int'(victim), 0);
    end else begin
      check("R6 R9 victim ok", int'(victim_ok), 1);
      check("R6 R9 victim idx", int'(victim), v);
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input bit u, input int idx, input bit w, input logic [5:0] d);
    string tag;
    use_vld  = u;
    use_idx  = 2'(idx);
    wr_en    = w;
    wr_state = d;
    @(posedge clk);
    if (w) begin
      m_st = d;
      tag = "R8 write";
    end else if (u) begin
      case (idx)
        0: begin m_st[5] = 0; m_st[4] = 0; m_st[3] = 0; tag = "R2 use0"; end
        1: begin m_st[5] = 1; m_st[2] = 0; m_st[1] = 0; tag = "R3 use1"; end
        2: begin m_st[4] = 1; m_st[2] = 1; m_st[0] = 0; tag = "R4 use2"; end
        default: begin m_st[3] = 1; m_st[1] = 1; m_st[0] = 1; tag = "R5 use3"; end
      endcase
    end else begin
      tag = "R10 idle";
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_st = 6'd0;
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(state), 0);
    check("R1 reset victim", int'(victim), 3);
    check("R1 reset ok", int'(victim_ok), 1);
    rst = 1'b0;
    step(0, 0, 0, 0);
    check("R1 after release victim", int'(victim), 3);
    // Each slot in turn from the reset state.
    step(1, 0, 0, 0);
    step(1, 3, 0, 0);
    step(1, 2, 0, 0);
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // Known illegal code, then a write colliding with a use.
    step(0, 0, 1, 6'b000010);
    check("R7 code 000010 ok", int'(victim_ok), 0);
    step(1, 3, 1, 6'b111000);
    check("R8 write beats use", int'(state), 6'b111000);
    check("R6 all-ones slot0 bits", int'(victim), 0);
    // Sweep every state code, then touch each slot from it.
    for (int c = 0; c < 64; c++) begin
      step(0, 0, 1, 6'(c));
      step(1, c % 4, 0, 0);
    end
    // Long mixed sequence.
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0)      step(0, 0, 1, 6'($urandom));
      else if (r == 1) step(1, int'($urandom_range(0, 3)), 1, 6'($urandom));
      else if (r == 2) step(0, 0, 0, 0);
      else             step(1, int'($urandom_range(0, 3)), 0, 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule